// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the configuration engine of an add-in card on a legacy parallel host bus. After reset the card ignores the host until it sees a 32-byte unlock sequence on the address port. It then sleeps until the host wakes it by card number. Through a wake with number zero it enters a bit-by-bit contest against the other cards. The winner of that contest takes a card number from the host. In the configuration state the host streams the card's resource description out of an external EEPROM. That path is one byte per request, and a status flag tells the host when a byte is waiting.

While configured, the host programs one logical device: a 16-bit I/O base and an IRQ level. A write of one to the activate register turns the attached function on and leaves configuration, so the card stops answering configuration reads. A strap input skips the whole sequence instead. On a reset taken with the strap high, the card comes up active with one of four preset port/IRQ pairs, and it ignores every host write.

The host interface is three strobes over a shared data byte: an address-port write that selects a register index, a data-port write and a read-port read. Reads return their byte in `rd_data` one clock after the strobe.

Top module: `pnp_cfg_ctrl`

## Requirements
- R1: A synchronous reset with the strap low clears the card number, the activate bit, `io_base` and `irq_lvl`, sets `rd_data` to 8'hFF and parks the card in the unlock-wait state, where reads return 8'hFF.
- R2: The card leaves unlock-wait when 32 address-port writes arrive in a row. They start at 8'h6A, and each following byte is the previous one shifted right by one with bit0 XOR bit1 placed in bit 7. Any wrong byte restarts the count, so the card stays locked.
- R3: A data write to register 8'h03 (wake) carrying the stored card number wakes a sleeping card. A stored number of zero leads to isolation and a nonzero one leads to configuration. A mismatching wake leaves a sleeping card asleep and sends an isolating or configured card to sleep.
- R4: In isolation, each read of register 8'h01 shows the next bit of CARD_ID, most significant first: 8'h55 for a one and 8'h00 for a zero. If the card's bit is zero while `iso_bus_bit` is high in the read cycle, the card loses and sleeps, and the next wake restarts from the first bit.
- R5: A write to register 8'h06 stores the card number and enters configuration, but only after all ID bits were read without losing. Before that the write is ignored. In configuration, register 8'h06 reads back the number.
- R6: Entering configuration requests EEPROM byte 0 with a single-cycle `ee_req`. Bit 0 of register 8'h05 reads one once the byte has arrived. A read of register 8'h04 while ready returns that byte, advances `ee_addr` by one and requests the next byte. A read while not ready returns the held byte and does not advance.
- R7: In configuration, registers 8'h60 (base high byte), 8'h61 (base low byte) and 8'h70 (IRQ, low 4 bits) are written and read back, and they drive `io_base` and `irq_lvl`.
- R8: In configuration, writing bit0 of register 8'h30 sets `func_en` and moves the card to the active state. There, configuration reads return 8'hFF and register writes are ignored. Writing zero clears `func_en` and keeps the card in configuration.
- R9: A write to register 8'h02 with bit2 set clears the card number. With bit1 set it returns the card to unlock-wait.
- R10: A reset with `bypass` high brings the card up active with `func_en` set. `com_sel` picks the port/IRQ pair: 0 gives 16'h3F8/4, 1 gives 16'h2F8/3, 2 gives 16'h3E8/4 and 3 gives 16'h2E8/3. All host writes and the unlock sequence are ignored.
- R11: In the active state the unlock sequence sends the card to sleep and `func_en` stays set, so a wake with its number reaches configuration again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bypass | input | 1 | Strap: skip automatic configuration |
| com_sel | input | 2 | Strap: preset port/IRQ pair for bypass |
| addr_we | input | 1 | Address-port write strobe |
| wr_we | input | 1 | Data-port write strobe |
| rd_re | input | 1 | Read-port strobe |
| bus_din | input | 8 | Host data byte |
| iso_bus_bit | input | 1 | Other cards' isolation drive seen on the bus |
| rd_data | output | 8 | Read data, valid the cycle after `rd_re` |
| ee_req | output | 1 | One-cycle EEPROM byte request |
| ee_addr | output | EE_AW | EEPROM byte address |
| ee_valid | input | 1 | EEPROM byte valid |
| ee_din | input | 8 | EEPROM byte |
| func_en | output | 1 | Attached function enable |
| io_base | output | IO_W | Programmed I/O base |
| irq_lvl | output | IRQ_W | Programmed IRQ level |

## Verification
The EEPROM can deliver a byte in the very cycle that the host reads the resource register, so the fetch path and the host read path meet on one clock edge. The bench takes manual control of `ee_valid` and raises it on the same edge as `rd_re` for register 8'h04. It then expects the returned byte to be the previously held one and `ee_addr` to stay unchanged. Afterwards the status bit should read one, and the following read should return the new byte and advance the address.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  typedef enum logic [2:0] {
    ST_LOCKED, ST_SLEEP, ST_ISOLATE, ST_CONFIG, ST_ACTIVE
  } cfg_state_t;

  localparam logic [7:0] RG_ISO  = 8'h01;
  localparam logic [7:0] RG_CTRL = 8'h02;
  localparam logic [7:0] RG_WAKE = 8'h03;
  localparam logic [7:0] RG_RES  = 8'h04;
  localparam logic [7:0] RG_STAT = 8'h05;
  localparam logic [7:0] RG_CSN  = 8'h06;
  localparam logic [7:0] RG_ACT  = 8'h30;
  localparam logic [7:0] RG_IOHI = 8'h60;
  localparam logic [7:0] RG_IOLO = 8'h61;
  localparam logic [7:0] RG_IRQ  = 8'h70;

  localparam logic [7:0] UNLOCK_SEED = 8'h6A;

  function automatic logic [7:0] unlock_step(input logic [7:0] v);
    return {v[0] ^ v[1], v[7:1]};
  endfunction
endpackage

// File: rtl/pnp_unlock_det.sv
module pnp_unlock_det #(
  parameter int KEY_LEN = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       wr,
  input  logic [7:0] din,
  output logic       hit
);
  import pnp_cfg_pkg::*;
  localparam int CW = $clog2(KEY_LEN);

  logic [CW-1:0] cnt;
  logic [7:0]    expect_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt      <= '0;
      expect_q <= UNLOCK_SEED;
      hit      <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (wr) begin
        if (din == expect_q) begin
          if (cnt == CW'(KEY_LEN - 1)) begin
            hit      <= 1'b1;
            cnt      <= '0;
            expect_q <= UNLOCK_SEED;
          end else begin
            cnt      <= cnt + 1'b1;
            expect_q <= unlock_step(expect_q);
          end
        end else if (din == UNLOCK_SEED) begin
          cnt      <= CW'(1);
          expect_q <= unlock_step(UNLOCK_SEED);
        end else begin
          cnt      <= '0;
          expect_q <= UNLOCK_SEED;
        end
      end
    end
  end
endmodule

// File: rtl/pnp_res_fetch.sv
module pnp_res_fetch #(
  parameter int EE_AW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             take,
  input  logic             ee_valid,
  input  logic [7:0]       ee_din,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_addr,
  output logic [7:0]       byte_q,
  output logic             ready
);
  logic busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ee_req  <= 1'b0;
      ee_addr <= '0;
      byte_q  <= '0;
      ready   <= 1'b0;
      busy    <= 1'b0;
    end else begin
      ee_req <= 1'b0;
      if (start) begin
        ee_addr <= '0;
        ready   <= 1'b0;
        busy    <= 1'b1;
        ee_req  <= 1'b1;
      end else begin
        if (busy && ee_valid) begin
          byte_q <= ee_din;
          ready  <= 1'b1;
          busy   <= 1'b0;
        end
        if (take && ready) begin
          ready   <= 1'b0;
          ee_addr <= ee_addr + 1'b1;
          busy    <= 1'b1;
          ee_req  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pnp_cfg_ctrl.sv
module pnp_cfg_ctrl #(
  parameter int               KEY_LEN = 32,
  parameter int               ID_BITS = 8,
  parameter logic [ID_BITS-1:0] CARD_ID = 8'hA5,
  parameter int               EE_AW   = 8,
  parameter int               IO_W    = 16,
  parameter int               IRQ_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic [1:0]       com_sel,
  input  logic             addr_we,
  input  logic             wr_we,
  input  logic             rd_re,
  input  logic [7:0]       bus_din,
  input  logic             iso_bus_bit,
  output logic [7:0]       rd_data,
  output logic             ee_req,
  output logic [EE_AW-1:0] ee_addr,
  input  logic             ee_valid,
  input  logic [7:0]       ee_din,
  output logic             func_en,
  output logic [IO_W-1:0]  io_base,
  output logic [IRQ_W-1:0] irq_lvl
);
  import pnp_cfg_pkg::*;
  localparam int ICW = (ID_BITS > 1) ? $clog2(ID_BITS) : 1;
  localparam int IOH = IO_W - 8;

  cfg_state_t     st;
  logic [7:0]     reg_idx;
  logic [7:0]     csn;
  logic [ICW-1:0] iso_cnt;
  logic           iso_won;
  logic           key_hit;
  logic           res_ready;
  logic [7:0]     res_byte;
  logic [7:0]     rd_val;
  logic           my_bit;
  logic           host_wr, host_rd, key_en, start_fetch, take;
  logic [IO_W-1:0]  preset_io;
  logic [IRQ_W-1:0] preset_irq;

  assign host_wr = wr_we && !bypass;
  assign host_rd = rd_re && !bypass;
  assign key_en  = (st == ST_LOCKED || st == ST_ACTIVE) && !bypass;
  assign my_bit  = CARD_ID[ICW'(ID_BITS - 1) - iso_cnt];

  assign start_fetch = host_wr &&
    ((st == ST_SLEEP && reg_idx == RG_WAKE && bus_din == csn && csn != 8'h00) ||
     (st == ST_ISOLATE && reg_idx == RG_CSN && iso_won));
  assign take = host_rd && st == ST_CONFIG && reg_idx == RG_RES;

  always_comb begin
    case (com_sel)
      2'd0:    begin preset_io = IO_W'(16'h03F8); preset_irq = IRQ_W'(4); end
      2'd1:    begin preset_io = IO_W'(16'h02F8); preset_irq = IRQ_W'(3); end
      2'd2:    begin preset_io = IO_W'(16'h03E8); preset_irq = IRQ_W'(4); end
      default: begin preset_io = IO_W'(16'h02E8); preset_irq = IRQ_W'(3); end
    endcase
  end

  pnp_unlock_det #(.KEY_LEN(KEY_LEN)) u_unlock (
    .clk(clk), .rst(rst), .en(key_en), .wr(addr_we), .din(bus_din), .hit(key_hit)
  );

  pnp_res_fetch #(.EE_AW(EE_AW)) u_fetch (
    .clk(clk), .rst(rst), .start(start_fetch), .take(take),
    .ee_valid(ee_valid), .ee_din(ee_din), .ee_req(ee_req), .ee_addr(ee_addr),
    .byte_q(res_byte), .ready(res_ready)
  );

  always_comb begin
    rd_val = 8'hFF;
    if (st == ST_ISOLATE && reg_idx == RG_ISO) begin
      rd_val = (!iso_won && my_bit) ? 8'h55 : 8'h00;
    end else if (st == ST_CONFIG) begin
      case (reg_idx)
        RG_RES:  rd_val = res_byte;
        RG_STAT: rd_val = {7'd0, res_ready};
        RG_CSN:  rd_val = csn;
        RG_ACT:  rd_val = {7'd0, func_en};
        RG_IOHI: rd_val = 8'(io_base[IO_W-1:8]);
        RG_IOLO: rd_val = io_base[7:0];
        RG_IRQ:  rd_val = 8'(irq_lvl);
        default: rd_val = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= bypass ? ST_ACTIVE : ST_LOCKED;
      func_en <= bypass;
      io_base <= bypass ? preset_io : '0;
      irq_lvl <= bypass ? preset_irq : '0;
      csn     <= 8'h00;
      rd_data <= 8'hFF;
      reg_idx <= 8'h00;
      iso_cnt <= '0;
      iso_won <= 1'b0;
    end else begin
      if (addr_we) reg_idx <= bus_din;
      if (host_rd) rd_data <= rd_val;

      if (host_rd && st == ST_ISOLATE && reg_idx == RG_ISO && !iso_won) begin
        if (!my_bit && iso_bus_bit) st <= ST_SLEEP;
        else if (iso_cnt == ICW'(ID_BITS - 1)) iso_won <= 1'b1;
        else iso_cnt <= iso_cnt + 1'b1;
      end

      case (st)
        ST_LOCKED, ST_ACTIVE: if (key_hit) st <= ST_SLEEP;
        default: if (host_wr) begin
          case (reg_idx)
            RG_CTRL: begin
              if (bus_din[2]) csn <= 8'h00;
              if (bus_din[1]) st  <= ST_LOCKED;
            end
            RG_WAKE: begin
              if (st == ST_SLEEP) begin
                if (bus_din == csn) begin
                  if (csn == 8'h00) begin
                    st      <= ST_ISOLATE;
                    iso_cnt <= '0;
                    iso_won <= 1'b0;
                  end else begin
                    st <= ST_CONFIG;
                  end
                end
              end else if (bus_din != csn) begin
                st <= ST_SLEEP;
              end
            end
            RG_CSN: if (st == ST_ISOLATE && iso_won) begin
              csn <= bus_din;
              st  <= ST_CONFIG;
            end
            RG_ACT: if (st == ST_CONFIG) begin
              func_en <= bus_din[0];
              if (bus_din[0]) st <= ST_ACTIVE;
            end
            RG_IOHI: if (st == ST_CONFIG) io_base <= {bus_din[IOH-1:0], io_base[7:0]};
            RG_IOLO: if (st == ST_CONFIG) io_base[7:0] <= bus_din;
            RG_IRQ:  if (st == ST_CONFIG) irq_lvl <= bus_din[IRQ_W-1:0];
            default: ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/pnp_cfg_chk.sv
module pnp_cfg_chk #(
  parameter int IO_W  = 16,
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             bypass,
  input logic             wr_we,
  input logic             rd_re,
  input logic [7:0]       rd_data,
  input logic             ee_req,
  input logic             func_en,
  input logic [IO_W-1:0]  io_base,
  input logic [IRQ_W-1:0] irq_lvl
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst && !bypass |=> !func_en && rd_data == 8'hFF && io_base == '0);

  p_req_single_r6: assert property (@(posedge clk) disable iff (rst)
    ee_req |=> !ee_req);

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_re |=> $stable(rd_data));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wr_we |=> $stable(io_base) && $stable(irq_lvl));

  p_enable_by_write_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(func_en) |-> $past(wr_we) && !bypass);

  p_bypass_hold_r10: assert property (@(posedge clk) disable iff (rst)
    bypass |=> func_en && $stable(io_base) && $stable(irq_lvl));
endmodule

bind pnp_cfg_ctrl pnp_cfg_chk #(.IO_W(IO_W), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .rst(rst), .bypass(bypass), .wr_we(wr_we), .rd_re(rd_re),
  .rd_data(rd_data), .ee_req(ee_req), .func_en(func_en),
  .io_base(io_base), .irq_lvl(irq_lvl)
);

// File: tb/sim_pnp_cfg_ctrl.sv
module sim_pnp_cfg_ctrl;
  import pnp_cfg_pkg::*;
  localparam logic [7:0] ID = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bypass = 1'b0;
  logic [1:0] com_sel = 2'd0;
  logic addr_we = 1'b0, wr_we = 1'b0, rd_re = 1'b0;
  logic [7:0] bus_din = 8'h00;
  logic iso_bus_bit = 1'b0;
  logic [7:0] rd_data;
  logic ee_req;
  logic [7:0] ee_addr;
  logic ee_valid;
  logic [7:0] ee_din;
  logic func_en;
  logic [15:0] io_base;
  logic [3:0] irq_lvl;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic ee_manual = 1'b0, m_valid = 1'b0;
  logic [7:0] m_data = 8'h00;
  logic a_valid = 1'b0, pend = 1'b0;
  logic [7:0] a_data = 8'h00, a_addr = 8'h00;
  logic [1:0] cnt = 2'd0;

  always #10 clk = ~clk;

  assign ee_valid = ee_manual ? m_valid : a_valid;
  assign ee_din   = ee_manual ? m_data : a_data;

  function automatic logic [7:0] rom(input logic [7:0] a);
    return a * 8'd7 + 8'h21;
  endfunction

  always @(posedge clk) begin
    a_valid <= 1'b0;
    if (rst || ee_manual) pend <= 1'b0;
    else if (ee_req) begin pend <= 1'b1; cnt <= 2'd2; a_addr <= ee_addr; end
    else if (pend) begin
      if (cnt == 2'd0) begin a_valid <= 1'b1; a_data <= rom(a_addr); pend <= 1'b0; end
      else cnt <= cnt - 1'b1;
    end
  end

  pnp_cfg_ctrl #(.CARD_ID(ID)) u0 (
    .clk(clk), .rst(rst), .bypass(bypass), .com_sel(com_sel),
    .addr_we(addr_we), .wr_we(wr_we), .rd_re(rd_re), .bus_din(bus_din),
    .iso_bus_bit(iso_bus_bit), .rd_data(rd_data), .ee_req(ee_req),
    .ee_addr(ee_addr), .ee_valid(ee_valid), .ee_din(ee_din),
    .func_en(func_en), .io_base(io_base), .irq_lvl(irq_lvl)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic byp, input logic [1:0] sel);
    @(negedge clk); rst = 1'b1; bypass = byp; com_sel = sel;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put_addr(input logic [7:0] d);
    @(negedge clk); addr_we = 1'b1; bus_din = d;
    @(negedge clk); addr_we = 1'b0;
  endtask

  task automatic put_data(input logic [7:0] d);
    @(negedge clk); wr_we = 1'b1; bus_din = d;
    @(negedge clk); wr_we = 1'b0;
  endtask

  task automatic wreg(input logic [7:0] idx, input logic [7:0] d);
    put_addr(idx); put_data(d);
  endtask

  task automatic rreg(input logic [7:0] idx, output logic [7:0] v, input logic bb = 1'b0);
    put_addr(idx);
    @(negedge clk); rd_re = 1'b1; iso_bus_bit = bb;
    @(negedge clk); rd_re = 1'b0; iso_bus_bit = 1'b0;
    v = rd_data;
  endtask

  task automatic send_key(input int bad_at);
    logic [7:0] k = 8'h6A;
    for (int i = 0; i < 32; i++) begin
      if (i == bad_at) put_addr(8'h00);
      put_addr(k);
      k = {k[0] ^ k[1], k[7:1]};
    end
  endtask

  task automatic to_config(input logic [7:0] num);
    logic [7:0] v;
    do_reset(1'b0, 2'd0);
    send_key(-1);
    wreg(RG_WAKE, 8'h00);
    for (int i = 0; i < 8; i++) rreg(RG_ISO, v);
    wreg(RG_CSN, num);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    do_reset(1'b0, 2'd0);
    chk("R1", "func_en", func_en, 0);
    chk("R1", "io_base", io_base, 0);
    chk("R1", "irq_lvl", irq_lvl, 0);
    chk("R1", "rd_data", rd_data, 8'hFF);
    chk("R1", "ee_req", ee_req, 0);
    rreg(RG_CSN, v);
    chk("R1", "read while locked", v, 8'hFF);
  endtask

  task automatic t_key;
    logic [7:0] v;
    do_reset(1'b0, 2'd0);
    send_key(10);
    wreg(RG_WAKE, 8'h00);
    rreg(RG_ISO, v);
    chk("R2", "broken key keeps lock", v, 8'hFF);
    send_key(-1);
    wreg(RG_WAKE, 8'h00);
    rreg(RG_ISO, v);
    chk("R2", "full key unlocks", v, 8'h55);
  endtask

  task automatic t_iso_win;
    logic [7:0] v;
    do_reset(1'b0, 2'd0);
    send_key(-1);
    wreg(RG_WAKE, 8'h00);
    for (int i = 0; i < 8; i++) begin
      if (i == 5) wreg(RG_CSN, 8'h09);
      rreg(RG_ISO, v);
      chk(i == 5 ? "R5" : "R4", "isolation bit", v, ID[7-i] ? 8'h55 : 8'h00);
    end
    wreg(RG_CSN, 8'h09);
    rreg(RG_CSN, v);
    chk("R5", "csn readback", v, 8'h09);
  endtask

  task automatic t_iso_lose;
    logic [7:0] v;
    do_reset(1'b0, 2'd0);
    send_key(-1);
    wreg(RG_WAKE, 8'h00);
    rreg(RG_ISO, v, 1'b1);
    chk("R4", "one bit survives bus", v, 8'h55);
    rreg(RG_ISO, v, 1'b1);
    chk("R4", "zero bit vs bus", v, 8'h00);
    rreg(RG_ISO, v);
    chk("R4", "loser sleeps", v, 8'hFF);
    wreg(RG_WAKE, 8'h00);
    rreg(RG_ISO, v);
    chk("R4", "restart at first bit", v, 8'h55);
  endtask

  task automatic t_wake;
    logic [7:0] v;
    to_config(8'h07);
    wreg(RG_WAKE, 8'h03);
    rreg(RG_CSN, v);
    chk("R3", "mismatch sleeps", v, 8'hFF);
    wreg(RG_WAKE, 8'h03);
    rreg(RG_CSN, v);
    chk("R3", "mismatch stays asleep", v, 8'hFF);
    wreg(RG_WAKE, 8'h07);
    rreg(RG_CSN, v);
    chk("R3", "match configures", v, 8'h07);
  endtask

  task automatic t_resource;
    logic [7:0] v;
    to_config(8'h04);
    for (int b = 0; b < 3; b++) begin
      v = 8'h00;
      for (int p = 0; p < 20 && v[0] == 1'b0; p++) rreg(RG_STAT, v);
      chk("R6", "byte ready", v, 8'h01);
      rreg(RG_RES, v);
      chk("R6", "resource byte", v, rom(8'(b)));
      chk("R6", "ee_addr advance", ee_addr, b + 1);
    end
  endtask

  task automatic t_collide;
    logic [7:0] v;
    ee_manual = 1'b1;
    to_config(8'h04);
    chk("R6", "first request address", ee_addr, 0);
    @(negedge clk); m_valid = 1'b1; m_data = 8'hC3;
    @(negedge clk); m_valid = 1'b0;
    rreg(RG_RES, v);
    chk("R6", "manual byte", v, 8'hC3);
    chk("R6", "addr after take", ee_addr, 1);
    put_addr(RG_RES);
    @(negedge clk); m_valid = 1'b1; m_data = 8'h3C; rd_re = 1'b1;
    @(negedge clk); m_valid = 1'b0; rd_re = 1'b0;
    chk("R6", "same-cycle read gives held byte", rd_data, 8'hC3);
    chk("R6", "same-cycle read no advance", ee_addr, 1);
    rreg(RG_STAT, v);
    chk("R6", "ready after arrival", v, 8'h01);
    rreg(RG_RES, v);
    chk("R6", "new byte", v, 8'h3C);
    chk("R6", "advance after new byte", ee_addr, 2);
    ee_manual = 1'b0;
  endtask

  task automatic t_regs;
    logic [7:0] v;
    to_config(8'h05);
    wreg(RG_IOHI, 8'h02);
    wreg(RG_IOLO, 8'hF8);
    wreg(RG_IRQ, 8'h05);
    chk("R7", "io_base", io_base, 16'h02F8);
    chk("R7", "irq_lvl", irq_lvl, 4'h5);
    rreg(RG_IOHI, v); chk("R7", "hi readback", v, 8'h02);
    rreg(RG_IOLO, v); chk("R7", "lo readback", v, 8'hF8);
    rreg(RG_IRQ, v);  chk("R7", "irq readback", v, 8'h05);
  endtask

  task automatic t_activate;
    logic [7:0] v;
    to_config(8'h05);
    wreg(RG_IOHI, 8'h03);
    chk("R8", "func_en before", func_en, 0);
    wreg(RG_ACT, 8'h01);
    chk("R8", "func_en set", func_en, 1);
    rreg(RG_CSN, v);
    chk("R8", "active ignores reads", v, 8'hFF);
    wreg(RG_IOHI, 8'h07);
    chk("R8", "active ignores writes", io_base, 16'h0300);
    send_key(-1);
    chk("R11", "func_en kept", func_en, 1);
    rreg(RG_CSN, v);
    chk("R11", "asleep after key", v, 8'hFF);
    wreg(RG_WAKE, 8'h05);
    rreg(RG_CSN, v);
    chk("R11", "reconfigured", v, 8'h05);
    wreg(RG_ACT, 8'h00);
    chk("R8", "func_en cleared", func_en, 0);
    rreg(RG_CSN, v);
    chk("R8", "still configuring", v, 8'h05);
  endtask

  task automatic t_control;
    logic [7:0] v;
    to_config(8'h05);
    wreg(RG_CTRL, 8'h04);
    rreg(RG_CSN, v);
    chk("R9", "csn cleared", v, 8'h00);
    wreg(RG_CTRL, 8'h02);
    rreg(RG_CSN, v);
    chk("R9", "back to lock", v, 8'hFF);
    wreg(RG_WAKE, 8'h00);
    rreg(RG_ISO, v);
    chk("R9", "wake ignored when locked", v, 8'hFF);
  endtask

  task automatic t_bypass;
    logic [7:0] v;
    do_reset(1'b1, 2'd2);
    chk("R10", "func_en", func_en, 1);
    chk("R10", "io_base sel2", io_base, 16'h03E8);
    chk("R10", "irq sel2", irq_lvl, 4);
    send_key(-1);
    wreg(RG_WAKE, 8'h00);
    rreg(RG_ISO, v);
    chk("R10", "sequence ignored", v, 8'hFF);
    wreg(RG_IOHI, 8'h00);
    chk("R10", "write ignored", io_base, 16'h03E8);
    do_reset(1'b1, 2'd1);
    chk("R10", "io_base sel1", io_base, 16'h02F8);
    chk("R10", "irq sel1", irq_lvl, 3);
    do_reset(1'b0, 2'd0);
    chk("R1", "strap off resets", func_en, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_key;
    t_iso_win;
    t_iso_lose;
    t_wake;
    t_resource;
    t_collide;
    t_regs;
    t_activate;
    t_control;
    t_bypass;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule